// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block is a synchronous model of a two-way bus transceiver. It has one path from port A to port B and one path from B to A. Each path has its own storage stage, which acts in one of three ways. It can pass data straight through as an open latch. It can keep its contents. It can load on the rising edge of a slow direction clock. Two controls pick the behaviour: the path's latch-open input and its direction clock.

Each output gives a data bus and a drive-enable bit per half. These two signals stand in for a real three-state pad. The A-to-B drive control is active high. The B-to-A drive control is active low. The drive control only decides whether the output is driven, and the storage keeps working while the output is off.

Everything runs on one fast system clock. The direction clocks, latch controls and drive controls are sampled inputs, and the block finds their edges itself. The datapath can work as two independent halves, each with its own set of controls. It can also work as one wide word, where the half-0 controls govern every half.

Top module: `bus_xcvr_core`

## Requirements
- R1: While `rst_n` is low, both stores are zero and `a_drv` and `b_drv` are all zero.
- R2: When a half's A-to-B latch control has been high for two system clocks, that half of `b_out` shows the `a_in` value from one system clock earlier.
- R3: When the latch control is low and the direction clock does not rise, the store keeps its value whatever `a_in` does.
- R4: When the latch control is low, a low-to-high change of the direction clock loads `a_in` into the store. The sampled clock goes high on one system edge, and the load happens on the next edge.
- R5: A high-to-low change of the direction clock while the latch control is low loads nothing.
- R6: `ab_oe` is active high. Two system clocks after `ab_oe[h]` changes, `b_drv[h]` equals `ab_oe[h]`.
- R7: `ba_oe_n` is active low. Two system clocks after `ba_oe_n[h]` changes, `a_drv[h]` equals its inverse.
- R8: The drive control has no effect on the storage. A value loaded while the drive is off appears on the data output, both while the drive is off and after it turns on.
- R9: When `wide_mode` is 0, each half follows only its own controls. Half h spans bits h*HALF_W up to (h+1)*HALF_W-1.
- R10: When `wide_mode` is 1, the half-0 controls govern every half in both directions, and the controls of the other halves are ignored.
- R11: If the latch control falls while the direction clock is already high, the store keeps the value it had before the fall. No load happens until the clock goes low and then rises again.
- R12: The B-to-A path behaves in the same way as the A-to-B path, using `ba_le`, `ba_clk` and `b_in`. Activity on one path leaves the other path's store and drive unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: half-0 controls govern all halves |
| a_in | input | HALF_W*HALVES | Data arriving at port A |
| b_in | input | HALF_W*HALVES | Data arriving at port B |
| ab_oe | input | HALVES | A-to-B drive control per half, active high |
| ab_le | input | HALVES | A-to-B latch-open control per half |
| ab_clk | input | HALVES | A-to-B direction clock per half |
| ba_oe_n | input | HALVES | B-to-A drive control per half, active low |
| ba_le | input | HALVES | B-to-A latch-open control per half |
| ba_clk | input | HALVES | B-to-A direction clock per half |
| b_out | output | HALF_W*HALVES | Data driven toward port B |
| b_drv | output | HALVES | Drive enable for b_out per half |
| a_out | output | HALF_W*HALVES | Data driven toward port A |
| a_drv | output | HALVES | Drive enable for a_out per half |

## Verification
The bench uses the defaults HALF_W=18 and HALVES=2, so it works on a 36-bit word split into two halves. With two halves it can hold one half open while the other half keeps its value. It can also show that controls on the upper half are ignored once `wide_mode` is set. Test values are chosen so that the two halves always hold different values, which lets the bench catch a load or a drive enable that lands in the wrong half.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Control bundle for one half of one direction
  typedef struct packed {
    logic oe;   // drive requested (already made active high)
    logic le;   // latch open
    logic dclk; // direction clock level
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_ctl_sel.sv
`timescale 1ns/1ps
module xcvr_ctl_sel
  import xcvr_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic                  wide_mode,
  input  dir_ctl_t [HALVES-1:0] raw,
  output dir_ctl_t [HALVES-1:0] sel
);
  for (genvar h = 0; h < HALVES; h++) begin : g_sel
    if (h == 0) begin : g_base
      assign sel[h] = raw[0];
    end else begin : g_follow
      assign sel[h] = wide_mode ? raw[0] : raw[h];
    end
  end
endmodule

// File: rtl/xcvr_ctl_sync.sv
`timescale 1ns/1ps
module xcvr_ctl_sync
  import xcvr_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dir_ctl_t [HALVES-1:0] ctl_in,
  output logic     [HALVES-1:0] oe_s,
  output logic     [HALVES-1:0] le_s,
  output logic     [HALVES-1:0] dclk_s,
  output logic     [HALVES-1:0] dclk_p,
  output logic     [HALVES-1:0] rise
);
  logic [HALVES-1:0] oe_nxt, le_nxt, dclk_nxt, dclk_p_nxt;

  always_comb begin
    for (int h = 0; h < HALVES; h++) begin
      oe_nxt[h]   = ctl_in[h].oe;
      le_nxt[h]   = ctl_in[h].le;
      dclk_nxt[h] = ctl_in[h].dclk;
    end
    dclk_p_nxt = dclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_s   <= '0;
      le_s   <= '0;
      dclk_s <= '0;
      dclk_p <= '0;
    end else begin
      oe_s   <= oe_nxt;
      le_s   <= le_nxt;
      dclk_s <= dclk_nxt;
      dclk_p <= dclk_p_nxt;
    end
  end

  assign rise = dclk_s & ~dclk_p;
endmodule

// File: rtl/xcvr_half_store.sv
`timescale 1ns/1ps
module xcvr_half_store #(
  parameter int HALF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_s,
  input  logic              rise,
  input  logic              oe_s,
  input  logic [HALF_W-1:0] d_in,
  output logic [HALF_W-1:0] q,
  output logic              drv
);
  logic              load_en;
  logic [HALF_W-1:0] q_nxt;

  always_comb begin
    load_en = le_s | rise;
    q_nxt   = load_en ? d_in : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      drv <= 1'b0;
    end else begin
      if (load_en) q <= q_nxt;
      drv <= oe_s;
    end
  end
endmodule

// File: rtl/bus_xcvr_core.sv
`timescale 1ns/1ps
module bus_xcvr_core
  import xcvr_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int HALVES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_mode,
  input  logic [HALF_W*HALVES-1:0]   a_in,
  input  logic [HALF_W*HALVES-1:0]   b_in,
  input  logic [HALVES-1:0]          ab_oe,
  input  logic [HALVES-1:0]          ab_le,
  input  logic [HALVES-1:0]          ab_clk,
  input  logic [HALVES-1:0]          ba_oe_n,
  input  logic [HALVES-1:0]          ba_le,
  input  logic [HALVES-1:0]          ba_clk,
  output logic [HALF_W*HALVES-1:0]   b_out,
  output logic [HALVES-1:0]          b_drv,
  output logic [HALF_W*HALVES-1:0]   a_out,
  output logic [HALVES-1:0]          a_drv
);
  localparam int BUS_W = HALF_W * HALVES;

  dir_ctl_t [HALVES-1:0] ab_raw, ba_raw, ab_sel, ba_sel;
  logic [HALVES-1:0] ab_oe_s, ab_le_s, ab_clk_s, ab_clk_p, ab_rise;
  logic [HALVES-1:0] ba_oe_s, ba_le_s, ba_clk_s, ba_clk_p, ba_rise;

  for (genvar h = 0; h < HALVES; h++) begin : g_raw
    assign ab_raw[h].oe   = ab_oe[h];
    assign ab_raw[h].le   = ab_le[h];
    assign ab_raw[h].dclk = ab_clk[h];
    assign ba_raw[h].oe   = ~ba_oe_n[h];
    assign ba_raw[h].le   = ba_le[h];
    assign ba_raw[h].dclk = ba_clk[h];
  end

  xcvr_ctl_sel #(.HALVES(HALVES)) u_ab_sel (
    .wide_mode(wide_mode), .raw(ab_raw), .sel(ab_sel)
  );
  xcvr_ctl_sel #(.HALVES(HALVES)) u_ba_sel (
    .wide_mode(wide_mode), .raw(ba_raw), .sel(ba_sel)
  );

  xcvr_ctl_sync #(.HALVES(HALVES)) u_ab_sync (
    .clk(clk), .rst_n(rst_n), .ctl_in(ab_sel),
    .oe_s(ab_oe_s), .le_s(ab_le_s), .dclk_s(ab_clk_s),
    .dclk_p(ab_clk_p), .rise(ab_rise)
  );
  xcvr_ctl_sync #(.HALVES(HALVES)) u_ba_sync (
    .clk(clk), .rst_n(rst_n), .ctl_in(ba_sel),
    .oe_s(ba_oe_s), .le_s(ba_le_s), .dclk_s(ba_clk_s),
    .dclk_p(ba_clk_p), .rise(ba_rise)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_half_store #(.HALF_W(HALF_W)) u_ab_store (
      .clk(clk), .rst_n(rst_n),
      .le_s(ab_le_s[h]), .rise(ab_rise[h]), .oe_s(ab_oe_s[h]),
      .d_in(a_in[h*HALF_W +: HALF_W]),
      .q(b_out[h*HALF_W +: HALF_W]), .drv(b_drv[h])
    );
    xcvr_half_store #(.HALF_W(HALF_W)) u_ba_store (
      .clk(clk), .rst_n(rst_n),
      .le_s(ba_le_s[h]), .rise(ba_rise[h]), .oe_s(ba_oe_s[h]),
      .d_in(b_in[h*HALF_W +: HALF_W]),
      .q(a_out[h*HALF_W +: HALF_W]), .drv(a_drv[h])
    );
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, ba_clk_s[0], ba_clk_p[0], BUS_W[0]};
endmodule

// File: rtl/xcvr_core_chk.sv
`timescale 1ns/1ps
module xcvr_core_chk #(
  parameter int HALF_W = 18,
  parameter int HALVES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wide_mode,
  input logic [HALF_W*HALVES-1:0] a_in,
  input logic [HALF_W*HALVES-1:0] b_in,
  input logic [HALF_W*HALVES-1:0] a_out,
  input logic [HALF_W*HALVES-1:0] b_out,
  input logic [HALVES-1:0]        b_drv,
  input logic                     ab_le_s0,
  input logic                     ab_clk_s0,
  input logic                     ab_clk_p0,
  input logic                     ba_le_s0
);
  // R2
  ab_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le_s0 |=> b_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0]));

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le_s0 && !(ab_clk_s0 && !ab_clk_p0)) |=> $stable(b_out[HALF_W-1:0]));

  // R4
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le_s0 && ab_clk_s0 && !ab_clk_p0) |=> b_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0]));

  // R12
  ba_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le_s0 |=> a_out[HALF_W-1:0] == $past(b_in[HALF_W-1:0]));

  if (HALVES > 1) begin : g_wide
    // R10
    wide_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode && $past(wide_mode) && $past(wide_mode, 2)) |-> (b_drv[1] == b_drv[0]));
  end
endmodule

bind bus_xcvr_core xcvr_core_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out), .b_drv(b_drv),
  .ab_le_s0(ab_le_s[0]), .ab_clk_s0(ab_clk_s[0]), .ab_clk_p0(ab_clk_p[0]),
  .ba_le_s0(ba_le_s[0])
);

// File: tb/test_bus_xcvr_core.sv
`timescale 1ns/1ps
module test_bus_xcvr_core;
  localparam int HW = 18;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [NH-1:0] ab_oe = '0, ab_le = '0, ab_clk = '0;
  logic [NH-1:0] ba_oe_n = '1, ba_le = '0, ba_clk = '0;
  logic [BW-1:0] b_out, a_out;
  logic [NH-1:0] b_drv, a_drv;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_xcvr_core #(.HALF_W(HW), .HALVES(NH)) i_bus_xcvr_core (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait three system edges, sample away from the edge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 b_out in reset", b_out, '0);
    chk("R1 a_out in reset", a_out, '0);
    chk("R1 drives in reset", {a_drv, b_drv}, '0);
    @(negedge clk); rst_n = 1'b1;
    settle();
    chk("R1 b_out after release", b_out, '0);
  endtask

  task automatic t_transparent();
    ab_oe = 2'b11; ab_le = 2'b11; a_in = 36'h1_2345_6789;
    settle();
    chk("R2 open latch", b_out, 36'h1_2345_6789);
    chk("R6 drive on", b_drv, 2'b11);
    a_in = 36'h2_AAAA_5555;
    @(posedge clk); @(negedge clk);
    chk("R2 one-clock follow", b_out, 36'h2_AAAA_5555);
  endtask

  task automatic t_hold_and_edges();
    ab_le = 2'b00; settle();
    a_in = 36'h3_0F0F_F0F0; settle();
    chk("R3 held with clock low", b_out, 36'h2_AAAA_5555);
    ab_clk = 2'b11; settle();
    chk("R4 rising capture", b_out, 36'h3_0F0F_F0F0);
    a_in = 36'h4_1111_2222; ab_clk = 2'b00; settle();
    chk("R5 falling no capture", b_out, 36'h3_0F0F_F0F0);
  endtask

  task automatic t_le_fall_clk_high();
    ab_clk = 2'b11; ab_le = 2'b11; a_in = 36'h5_5A5A_A5A5; settle();
    ab_le = 2'b00; settle();
    a_in = 36'h6_7777_8888; settle();
    chk("R11 keep value after latch close", b_out, 36'h5_5A5A_A5A5);
    ab_clk = 2'b00; settle();
    chk("R11 no load on clock low", b_out, 36'h5_5A5A_A5A5);
    ab_clk = 2'b11; settle();
    chk("R11 load on next rise", b_out, 36'h6_7777_8888);
  endtask

  task automatic t_oe();
    ab_clk = 2'b00; ab_oe = 2'b00; settle();
    chk("R6 drive off", b_drv, 2'b00);
    a_in = 36'h7_1234_4321; ab_clk = 2'b11; settle();
    chk("R8 load while undriven", b_out, 36'h7_1234_4321);
    ab_oe = 2'b11; settle();
    chk("R8 value after drive on", b_out, 36'h7_1234_4321);
    chk("R6 drive back on", b_drv, 2'b11);
  endtask

  task automatic t_ba();
    ba_oe_n = 2'b00; ba_le = 2'b11; b_in = 36'h8_CAFE_BEEF; settle();
    chk("R7 active-low drive on", a_drv, 2'b11);
    chk("R12 B-to-A open latch", a_out, 36'h8_CAFE_BEEF);
    chk("R12 A-to-B untouched", b_out, 36'h7_1234_4321);
    ba_le = 2'b00; b_in = 36'h9_0000_0001; settle();
    ba_clk = 2'b11; settle();
    chk("R12 B-to-A rising capture", a_out, 36'h9_0000_0001);
    ba_oe_n = 2'b11; settle();
    chk("R7 active-low drive off", a_drv, 2'b00);
    chk("R12 B drive untouched", b_drv, 2'b11);
  endtask

  task automatic t_split();
    wide_mode = 1'b0; ab_clk = 2'b00; ab_le = 2'b01; ab_oe = 2'b01;
    a_in = 36'hA_BBBB_CCCC; settle();
    chk("R9 low half open, high half held", b_out, {18'h1_C48D, 18'h3_CCCC});
    chk("R9 per-half drive", b_drv, 2'b01);
  endtask

  task automatic t_wide();
    ab_le = 2'b00; ab_oe = 2'b00; ab_clk = 2'b00; settle();
    wide_mode = 1'b1; settle();
    a_in = 36'hB_DDDD_EEEE; ab_clk = 2'b01; settle();
    chk("R10 half-0 clock loads both halves", b_out, 36'hB_DDDD_EEEE);
    ab_oe = 2'b01; settle();
    chk("R10 half-0 drive for both", b_drv, 2'b11);
    ab_le = 2'b10; ab_clk = 2'b11; a_in = 36'hC_1357_2468; settle();
    ab_clk = 2'b10; settle();
    chk("R10 high-half controls ignored", b_out, 36'hB_DDDD_EEEE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_transparent();
    t_hold_and_edges();
    t_le_fall_clk_high();
    t_oe();
    t_ba();
    t_split();
    t_wide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule